// File: doc/BRIEF.md
# Event Timer Register File

This block is the software-facing register file of a multi-channel event timer. It decodes a 1 KB address window that takes only 32-bit accesses. The window holds a read-only capability word, a global configuration word, an interrupt status view, the 64-bit main tick counter, and one 32-byte window per timer channel. Each 64-bit register is exposed as two 32-bit halves.

The block also owns the main counter. The counter advances once per clock while the global enable bit is set and holds its value while the bit is clear. On each edge of the enable bit the block emits one-cycle arm or disarm pulses to the channel logic. Comparison, periodic reload and interrupt delivery sit in neighbouring blocks. Those blocks consume the per-channel configuration, comparator and route registers from this block, and they supply the raw interrupt status.

The bus side accepts one request per cycle and returns read data one cycle after the read is accepted.

Top module: `evt_regfile`

## Requirements
- R1: After reset the main counter and the global configuration are zero. Every channel configuration reads 0x00000030 (periodic-capable bit 4, 64-bit-capable bit 5). Every channel capability half reads 0x00000004 (routing input 2 available). Every comparator is all ones and every route register is zero.
- R2: Offset 0x000 reads 0x8086A001 with the channel count minus one ORed into bits 12:8. Offset 0x004 reads the tick period in femtoseconds (TICK_FS). Writes to either offset are ignored.
- R3: The main counter grows by exactly one per clock while global configuration bit 0 (enable) is set. It holds its value while that bit is clear, and the carry crosses from the low half into the high half.
- R4: Offset 0x0F0 writes the counter's low half and offset 0x0F4 writes its high half. Each write leaves the other half unchanged and replaces the increment in that cycle. Both offsets read the corresponding half.
- R5: A write to the global configuration at 0x010 updates only bits 1:0 (bit 0 enable, bit 1 legacy routing). Offset 0x014 reads zero and ignores writes.
- R6: The cycle after a write turns the enable bit from 0 to 1, ch_arm pulses for exactly those channels whose comparator is not all ones. The cycle after a write turns it from 1 to 0, ch_disarm pulses for every channel. Otherwise neither pulses.
- R7: Channel n owns offsets 0x100 + 0x20*n. A configuration write at +0x00 updates only the bits in mask 0x00007F4E. The capability half at +0x04 is read-only.
- R8: The comparator halves sit at +0x08 (low) and +0x0C (high), and the route halves at +0x10 (low) and +0x14 (high). Each half is written independently. ch_cmp_wr pulses for the channel in the cycle after either comparator half is written.
- R9: Windows whose channel index is at or beyond NUM_CH read zero and ignore writes. Unmapped offsets read zero.
- R10: Offset 0x020 reads irq_status in its low NUM_CH bits. Writing it pulses status_clr for one cycle with the bits that are set both in the write data and in irq_status.
- R11: bus_ready is always high. Every accepted read returns rd_valid with rd_data exactly one cycle later, and writes never raise rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Request present |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset inside the 1 KB window |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted (always high) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq_status | input | NUM_CH | Raw interrupt status from the channels |
| status_clr | output | NUM_CH | One-cycle clear pulses for status bits |
| glb_enable | output | 1 | Global enable bit |
| glb_legacy | output | 1 | Legacy routing bit |
| main_count | output | 64 | Main tick counter |
| ch_cfg | output | NUM_CH*32 | Channel configuration words |
| ch_cmp | output | NUM_CH*64 | Channel comparators |
| ch_route | output | NUM_CH*64 | Channel route registers |
| ch_cmp_wr | output | NUM_CH | Comparator-written pulses |
| ch_arm | output | NUM_CH | Arm pulses on enable rise |
| ch_disarm | output | NUM_CH | Disarm pulses on enable fall |

## Verification
The bench loads the counter low half with a value two ticks short of a carry and then enables it. A counter whose carry does not reach the high half, or one that runs while disabled, shows a wrong value after a known number of cycles. The bench writes a counter half while the counter runs, which exposes a design that lets the increment win over the write or that corrupts the other half. The arm pulse is checked against one channel with a programmed comparator and two channels left at all ones, so a design that arms every channel or none on the enable rise fails. Writes to a window beyond the implemented channels, to the capability word and to the upper global word are read back, which catches aliasing into channel 0 and writable read-only fields.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the event timer register file.
// Assumes a 10-bit byte address and 32-bit bus data.
package evt_pkg;
    localparam int HALF_W = 32;
    localparam int ADDR_W = 10;

    localparam logic [ADDR_W-1:0] OFF_CAP     = 10'h000;
    localparam logic [ADDR_W-1:0] OFF_PERIOD  = 10'h004;
    localparam logic [ADDR_W-1:0] OFF_GCFG    = 10'h010;
    localparam logic [ADDR_W-1:0] OFF_GCFG_HI = 10'h014;
    localparam logic [ADDR_W-1:0] OFF_STATUS  = 10'h020;
    localparam logic [ADDR_W-1:0] OFF_CNT_LO  = 10'h0F0;
    localparam logic [ADDR_W-1:0] OFF_CNT_HI  = 10'h0F4;
    localparam logic [ADDR_W-1:0] WIN_BASE    = 10'h100;
    localparam int               WIN_SHIFT   = 5;
    localparam int               WIN_COUNT   = 24;

    localparam logic [HALF_W-1:0] CAP_BASE    = 32'h8086_A001;
    localparam int               CAP_CNT_LSB = 8;
    localparam logic [HALF_W-1:0] GCFG_MASK   = 32'h0000_0003;
    localparam logic [HALF_W-1:0] CH_CFG_MASK = 32'h0000_7F4E;
    localparam logic [HALF_W-1:0] CH_CFG_RST  = 32'h0000_0030;
    localparam logic [HALF_W-1:0] CH_CAP_RST  = 32'h0000_0004;

    // Register selected inside one channel window
    typedef enum logic [2:0] {
        FLD_NONE, FLD_CFG, FLD_CAP, FLD_CMP_LO, FLD_CMP_HI, FLD_RT_LO, FLD_RT_HI
    } ch_field_e;
endpackage

// File: rtl/evt_main_counter.sv
`timescale 1ns/1ps
// Main tick counter: counts one per clock while run is high, holds
// otherwise; each 32-bit half is writable and a write beats the increment.
// Assumes the caller never asserts both write strobes with different data.
module evt_main_counter
    import evt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wdata,
    output logic [2*HALF_W-1:0] count
);
    // Counter register: half writes first, then increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_lo || wr_hi) begin
            count <= {wr_hi ? wdata : count[2*HALF_W-1:HALF_W],
                      wr_lo ? wdata : count[HALF_W-1:0]};
        end else if (run) begin
            count <= count + 1'b1;
        end
    end

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_lo && !wr_hi) |=> count == $past(count) + 1'b1);
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(count));
    a_r4_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> count[2*HALF_W-1:HALF_W] == $past(count[2*HALF_W-1:HALF_W]));
endmodule

// File: rtl/evt_chan_regs.sv
`timescale 1ns/1ps
// Register set of one timer channel: masked configuration, read-only
// capability half, split comparator and route registers, read mux.
// Assumes wr_en is already qualified with the channel select.
module evt_chan_regs
    import evt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  ch_field_e           field,
    input  logic [HALF_W-1:0]   wdata,
    output logic [HALF_W-1:0]   cfg,
    output logic [2*HALF_W-1:0] cmp,
    output logic [2*HALF_W-1:0] route,
    output logic                cmp_wr,
    output logic [HALF_W-1:0]   rdata
);
    // Register updates for the selected field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg    <= CH_CFG_RST;
            cmp    <= '1;
            route  <= '0;
            cmp_wr <= 1'b0;
        end else begin
            cmp_wr <= wr_en && (field == FLD_CMP_LO || field == FLD_CMP_HI);
            if (wr_en) begin
                case (field)
                    FLD_CFG:    cfg <= (wdata & CH_CFG_MASK) | (cfg & ~CH_CFG_MASK);
                    FLD_CMP_LO: cmp[HALF_W-1:0] <= wdata;
                    FLD_CMP_HI: cmp[2*HALF_W-1:HALF_W] <= wdata;
                    FLD_RT_LO:  route[HALF_W-1:0] <= wdata;
                    FLD_RT_HI:  route[2*HALF_W-1:HALF_W] <= wdata;
                    default:    ;
                endcase
            end
        end
    end

    // Read mux for the window
    always_comb begin
        case (field)
            FLD_CFG:    rdata = cfg;
            FLD_CAP:    rdata = CH_CAP_RST;
            FLD_CMP_LO: rdata = cmp[HALF_W-1:0];
            FLD_CMP_HI: rdata = cmp[2*HALF_W-1:HALF_W];
            FLD_RT_LO:  rdata = route[HALF_W-1:0];
            FLD_RT_HI:  rdata = route[2*HALF_W-1:HALF_W];
            default:    rdata = '0;
        endcase
    end

    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg) && $stable(cmp) && $stable(route));
    a_r7_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cfg & ~CH_CFG_MASK) == CH_CFG_RST);
endmodule

// File: rtl/evt_regfile.sv
`timescale 1ns/1ps
// Event timer register file: decodes the 1 KB window, holds global
// configuration, drives the main counter and per-channel registers,
// and emits arm/disarm pulses on global enable edges.
// Assumes 32-bit aligned accesses and NUM_CH between 1 and 24.
module evt_regfile
    import evt_pkg::*;
#(
    parameter int          NUM_CH  = 3,
    parameter logic [31:0] TICK_FS = 32'd10_000_000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [HALF_W-1:0]        bus_wdata,
    output logic                     bus_ready,
    output logic                     rd_valid,
    output logic [HALF_W-1:0]        rd_data,
    input  logic [NUM_CH-1:0]        irq_status,
    output logic [NUM_CH-1:0]        status_clr,
    output logic                     glb_enable,
    output logic                     glb_legacy,
    output logic [2*HALF_W-1:0]      main_count,
    output logic [NUM_CH*HALF_W-1:0] ch_cfg,
    output logic [NUM_CH*2*HALF_W-1:0] ch_cmp,
    output logic [NUM_CH*2*HALF_W-1:0] ch_route,
    output logic [NUM_CH-1:0]        ch_cmp_wr,
    output logic [NUM_CH-1:0]        ch_arm,
    output logic [NUM_CH-1:0]        ch_disarm
);
    localparam int IDX_W = ADDR_W - WIN_SHIFT;
    localparam logic [IDX_W-1:0] WIN_FIRST = IDX_W'(WIN_BASE >> WIN_SHIFT);
    localparam logic [HALF_W-1:0] CAP_WORD =
        CAP_BASE | (HALF_W'(NUM_CH - 1) << CAP_CNT_LSB);

    logic              acc_rd, acc_wr, in_win;
    logic [IDX_W-1:0]  win_idx;
    ch_field_e         field;
    logic [NUM_CH-1:0] ch_sel;
    logic [HALF_W-1:0] ch_rd [NUM_CH];
    logic [HALF_W-1:0] gcfg_q, rd_mux;
    logic              cnt_wr_lo, cnt_wr_hi, gcfg_wr, en_rise, en_fall;

    assign bus_ready = 1'b1;
    assign acc_rd    = bus_valid && !bus_write;
    assign acc_wr    = bus_valid && bus_write;
    assign in_win    = bus_addr >= WIN_BASE;
    assign win_idx   = bus_addr[ADDR_W-1:WIN_SHIFT] - WIN_FIRST;
    assign cnt_wr_lo = acc_wr && bus_addr == OFF_CNT_LO;
    assign cnt_wr_hi = acc_wr && bus_addr == OFF_CNT_HI;
    assign gcfg_wr   = acc_wr && bus_addr == OFF_GCFG;
    assign en_rise   = gcfg_wr && !gcfg_q[0] && bus_wdata[0];
    assign en_fall   = gcfg_wr && gcfg_q[0] && !bus_wdata[0];
    assign glb_enable = gcfg_q[0];
    assign glb_legacy = gcfg_q[1];

    // Field decode inside a channel window
    always_comb begin
        case (bus_addr[WIN_SHIFT-1:0])
            5'h00:   field = FLD_CFG;
            5'h04:   field = FLD_CAP;
            5'h08:   field = FLD_CMP_LO;
            5'h0C:   field = FLD_CMP_HI;
            5'h10:   field = FLD_RT_LO;
            5'h14:   field = FLD_RT_HI;
            default: field = FLD_NONE;
        endcase
    end

    evt_main_counter u_counter (
        .clk(clk), .rst_n(rst_n), .run(gcfg_q[0]),
        .wr_lo(cnt_wr_lo), .wr_hi(cnt_wr_hi),
        .wdata(bus_wdata), .count(main_count)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign ch_sel[i] = in_win && win_idx == IDX_W'(i);
        evt_chan_regs u_ch (
            .clk(clk), .rst_n(rst_n),
            .wr_en(acc_wr && ch_sel[i]), .field(field), .wdata(bus_wdata),
            .cfg(ch_cfg[i*HALF_W +: HALF_W]),
            .cmp(ch_cmp[i*2*HALF_W +: 2*HALF_W]),
            .route(ch_route[i*2*HALF_W +: 2*HALF_W]),
            .cmp_wr(ch_cmp_wr[i]),
            .rdata(ch_rd[i])
        );
    end

    // Global configuration and edge pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcfg_q     <= '0;
            ch_arm     <= '0;
            ch_disarm  <= '0;
            status_clr <= '0;
        end else begin
            if (gcfg_wr) begin
                gcfg_q <= (bus_wdata & GCFG_MASK) | (gcfg_q & ~GCFG_MASK);
            end
            for (int i = 0; i < NUM_CH; i++) begin
                ch_arm[i] <= en_rise && (ch_cmp[i*2*HALF_W +: 2*HALF_W] != '1);
            end
            ch_disarm  <= en_fall ? '1 : '0;
            status_clr <= (acc_wr && bus_addr == OFF_STATUS) ?
                          (bus_wdata[NUM_CH-1:0] & irq_status) : '0;
        end
    end

    // Read data selection
    always_comb begin
        rd_mux = '0;
        if (in_win) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_sel[i]) rd_mux = ch_rd[i];
            end
        end else begin
            case (bus_addr)
                OFF_CAP:    rd_mux = CAP_WORD;
                OFF_PERIOD: rd_mux = TICK_FS;
                OFF_GCFG:   rd_mux = gcfg_q;
                OFF_STATUS: rd_mux = HALF_W'(irq_status);
                OFF_CNT_LO: rd_mux = main_count[HALF_W-1:0];
                OFF_CNT_HI: rd_mux = main_count[2*HALF_W-1:HALF_W];
                default:    rd_mux = '0;
            endcase
        end
    end

    // Read response register, one cycle latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_rd;
            if (acc_rd) rd_data <= rd_mux;
        end
    end

    a_r11_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rd_valid);
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> !rd_valid);
    a_r6_arm_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_arm) |-> $rose(glb_enable));
    a_r6_disarm_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_disarm) |-> $fell(glb_enable));
    a_r10_clr_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (|status_clr) |-> (status_clr & ~$past(irq_status)) == '0);
    a_r5_gcfg_bits: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (gcfg_q & ~GCFG_MASK) == '0);
endmodule

// File: tb/test_evt_regfile.sv
`timescale 1ns/1ps
module test_evt_regfile;
    localparam int NCH = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_ready, rd_valid, glb_enable, glb_legacy;
    logic [31:0] rd_data;
    logic [NCH-1:0] irq_status = '0;
    logic [NCH-1:0] status_clr, ch_cmp_wr, ch_arm, ch_disarm;
    logic [63:0] main_count;
    logic [NCH*32-1:0] ch_cfg;
    logic [NCH*64-1:0] ch_cmp, ch_route;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    evt_regfile #(.NUM_CH(NCH)) i_evt_regfile (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq_status(irq_status),
        .status_clr(status_clr), .glb_enable(glb_enable), .glb_legacy(glb_legacy),
        .main_count(main_count), .ch_cfg(ch_cfg), .ch_cmp(ch_cmp),
        .ch_route(ch_route), .ch_cmp_wr(ch_cmp_wr), .ch_arm(ch_arm),
        .ch_disarm(ch_disarm)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one read, expected value pushed to the scoreboard
    task automatic rd(logic [9:0] a, logic [31:0] exp, string tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        check("R11 no rd_valid after write", 64'(rd_valid), 64'd0);
    endtask

    // Monitor: pops expectations as read data appears
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected rd_valid", 64'd1, 64'd0);
            end else begin
                check(tag_q.pop_front(), 64'(rd_data), 64'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] snap;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 counter", main_count, 64'd0);
        check("R1 enable", 64'(glb_enable), 64'd0);
        check("R1 ch0 cfg port", 64'(ch_cfg[31:0]), 64'h30);
        check("R1 ch2 cmp port", ch_cmp[191:128], '1);
        check("R11 ready", 64'(bus_ready), 64'd1);
        rd(10'h100, 32'h30, "R1 ch0 cfg");
        rd(10'h124, 32'h4, "R1 ch1 cap half");
        rd(10'h150, 32'h0, "R1 ch2 route");
        rd(10'h010, 32'h0, "R1 gcfg");
        // R2 capability
        rd(10'h000, 32'h8086_A201, "R2 cap low");
        rd(10'h004, 32'h0098_9680, "R2 period");
        wr(10'h000, 32'hFFFF_FFFF);
        wr(10'h004, 32'h0);
        rd(10'h000, 32'h8086_A201, "R2 cap write ignored");
        rd(10'h004, 32'h0098_9680, "R2 period write ignored");
        // R5 global config mask
        wr(10'h010, 32'hFFFF_FFFC);
        rd(10'h010, 32'h0, "R5 masked gcfg");
        wr(10'h014, 32'hFFFF_FFFF);
        rd(10'h014, 32'h0, "R5 upper gcfg");
        rd(10'h010, 32'h0, "R5 upper write ignored");
        // R7 channel config mask and read-only capability half
        wr(10'h120, 32'hFFFF_FFFF);
        rd(10'h120, 32'h7F7E, "R7 ch1 cfg masked");
        wr(10'h124, 32'h0);
        rd(10'h124, 32'h4, "R7 ch1 cap read-only");
        // R8 comparator and route halves
        wr(10'h128, 32'h0000_1234);
        check("R8 cmp_wr pulse", 64'(ch_cmp_wr), 64'b010);
        wr(10'h12C, 32'h0);
        wr(10'h150, 32'hAAAA_5555);
        wr(10'h154, 32'h1);
        check("R8 ch1 cmp port", ch_cmp[127:64], 64'h1234);
        check("R8 ch2 route port", ch_route[191:128], 64'h1_AAAA_5555);
        rd(10'h128, 32'h1234, "R8 cmp low");
        rd(10'h12C, 32'h0, "R8 cmp high");
        rd(10'h154, 32'h1, "R8 route high");
        // R9 out-of-range windows and unmapped offsets
        wr(10'h160, 32'hFFFF_FFFF);
        wr(10'h3E8, 32'h0);
        rd(10'h160, 32'h0, "R9 window 3 cfg");
        rd(10'h3E8, 32'h0, "R9 window 23 cmp");
        rd(10'h100, 32'h30, "R9 no alias into ch0");
        rd(10'h008, 32'h0, "R9 unmapped 0x008");
        rd(10'h0F8, 32'h0, "R9 unmapped 0x0F8");
        rd(10'h118, 32'h0, "R9 unmapped in window");
        // R3/R4 frozen counter written by halves
        wr(10'h0F0, 32'hFFFF_FFFE);
        wr(10'h0F4, 32'h0);
        repeat (5) @(negedge clk);
        rd(10'h0F0, 32'hFFFF_FFFE, "R3 frozen low");
        rd(10'h0F4, 32'h0, "R4 high half");
        // R6 arm, R3 counting with carry
        wr(10'h010, 32'h1);
        check("R6 arm only ch1", 64'(ch_arm), 64'b010);
        check("R6 no disarm", 64'(ch_disarm), 64'd0);
        check("R3 count at enable", main_count, 64'hFFFF_FFFE);
        repeat (5) @(negedge clk);
        check("R3 carry into high", main_count, 64'h1_0000_0003);
        // R4 write beats increment, keeps other half
        wr(10'h0F4, 32'h10);
        check("R4 high write while running", main_count, 64'h10_0000_0003);
        // R6 disarm and R3 freeze
        wr(10'h010, 32'h0);
        check("R6 disarm all", 64'(ch_disarm), 64'b111);
        check("R6 no arm", 64'(ch_arm), 64'd0);
        snap = main_count;
        repeat (5) @(negedge clk);
        check("R3 frozen after disable", main_count, snap);
        // R10 status
        irq_status = 3'b101;
        rd(10'h020, 32'h5, "R10 status read");
        wr(10'h020, 32'h6);
        check("R10 clear pulse", 64'(status_clr), 64'b100);
        @(negedge clk);
        check("R10 pulse ends", 64'(status_clr), 64'd0);
        repeat (2) @(negedge clk);
        check("R11 all reads answered", 64'(exp_q.size()), 64'd0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule